// File: doc/BRIEF.md
# Banked SRAM Cartridge Mapper with Peripheral Window

This block sits between the bus of an 8-bit CPU cartridge slot and two devices: a battery-backed SRAM and an external SCSI protocol controller. The CPU window from 0x4000 to 0xBFFF is split into four 8 KB pages. Each page has its own bank register. A bank register points the page either at an 8 KB block of SRAM or at a register window of the controller. The CPU loads these registers by writing into 0x6000–0x7FFF. In each bank value, bit 7 grants write permission, and the pattern 01 in bits 7:6 selects the controller window.

The bus protocol is synchronous and takes one cycle per access. The mapper turns each access into an SRAM address and write enable, or into controller strobes. It also steers read data back to the CPU. The SRAM size is a parameter of 128, 256, 512 or 1024 KB, and it sets the mask applied to bank numbers.

Top module: `cart_bank_mapper`

## Requirements
- R1: In a memory-mapped page, the SRAM byte address is the page's bank number times 0x2000 plus `cpu_addr[12:0]`. Page n covers 0x4000 + n·0x2000.
- R2: A selected write anywhere in 0x6000–0x7FFF loads the bank register of page `cpu_addr[12:11]`. It raises neither `sram_we` nor `ctl_wr`.
- R3: Bit 7 of a loaded bank value is the page's write permission. A write to a page whose permission is clear leaves `sram_we` low and leaves the SRAM unchanged.
- R4: A bank value with bits 7:6 = 01 maps the page to the controller. Page offsets below 0x1000 reach the data register (`ctl_dsel`=1). Offsets 0x1000–0x1FFF reach register `cpu_addr[3:0]` (`ctl_dsel`=0). Read data then comes from `ctl_rdata`. The value 11xxxxxx stays memory-mapped.
- R5: In a memory mapping, the stored bank number is the value ANDed with (SRAM_KB/8)−1, so larger numbers mirror lower blocks.
- R6: A read outside 0x4000–0xBFFF, or any read while `slot_sel` is low, returns 0xFF. Accesses with `slot_sel` low change nothing.
- R7: A reset returns all four pages to bank 0, read-only, memory-mapped. `ctl_rst` is high while `rst_n` is low and falls at the first clock edge after release.
- R8: A read of a controller-mapped page gives exactly one cycle of `ctl_rd`, even when `cpu_rd` is held for several cycles.
- R9: Bank registers cannot be read back. A read in 0x6000–0x7FFF follows whatever page 1 currently maps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_sel | input | 1 | Cartridge slot selected; qualifies both strobes |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data to the CPU |
| sram_addr | output | log2(SRAM_KB)+10 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write enable, sampled at the clock edge |
| sram_rdata | input | 8 | SRAM read data (combinational) |
| ctl_reg | output | 4 | Controller register number |
| ctl_dsel | output | 1 | Access targets the controller data register |
| ctl_rd | output | 1 | Controller read strobe, one cycle |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data (combinational) |
| ctl_rst | output | 1 | Reset to the controller |

## Verification
The bench builds the mapper with SRAM_KB = 128. The bank mask is then only 0x0F, so values such as 0x93 and 0xBE fold onto blocks 3 and 14. This makes it possible to show one SRAM byte through two differently numbered banks. The small size also keeps the address space small enough for a sparse memory model with a computed background pattern. Every unwritten byte then has a known, address-dependent value. The controller model's data register advances on each read, so a doubled read strobe would shift every later expected value.

// File: rtl/cbm_pkg.sv
// Package: shared constants and the per-page mapping record for the
// banked cartridge mapper. Assumes four 8 KB pages in a 32 KB window.
package cbm_pkg;

    localparam int PAGE_COUNT = 4;
    localparam int PAGE_BITS  = 13;   // 8 KB per page
    localparam int MAX_BANK_W = 7;    // 1024 KB / 8 KB = 128 blocks

    // One page's mapping as held in its bank register.
    typedef struct packed {
        logic                  wen;     // CPU writes allowed to SRAM
        logic                  periph;  // page shows the controller window
        logic [MAX_BANK_W-1:0] bank;    // masked SRAM block number
    } page_map_t;

endpackage

// File: rtl/cbm_page_regs.sv
// Module: four write-only bank registers, one per page.
// Decodes a loaded value into write permission, controller redirect and a
// bank number masked to the SRAM size. Assumes ld_en is a one-cycle pulse
// already qualified by slot select and the bank-write address range.
module cbm_page_regs
    import cbm_pkg::*;
#(
    parameter int SRAM_KB = 1024
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_en,
    input  logic [1:0]                       ld_idx,
    input  logic [7:0]                       ld_val,
    output page_map_t [PAGE_COUNT-1:0]       maps
);

    localparam int                    BLOCKS    = SRAM_KB / 8;
    localparam logic [MAX_BANK_W-1:0] BANK_MASK = MAX_BANK_W'(BLOCKS - 1);

    // Value decode shared by all pages.
    logic      to_periph;
    page_map_t ld_map;

    // Purpose: turn the written byte into a mapping record.
    always_comb begin
        to_periph     = (ld_val[7:6] == 2'b01);
        ld_map.wen    = ld_val[7];
        ld_map.periph = to_periph;
        ld_map.bank   = to_periph ? '0 : (ld_val[6:0] & BANK_MASK);
    end

    for (genvar i = 0; i < PAGE_COUNT; i++) begin : g_page
        // Purpose: hold page i's mapping; reset to bank 0, read-only, memory.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                maps[i] <= '0;
            end else if (ld_en && (ld_idx == 2'(i))) begin
                maps[i] <= ld_map;
            end
        end

        AST_PERIPH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && ld_idx == 2'(i) && ld_val[7:6] == 2'b01)
                |=> (maps[i].periph && !maps[i].wen)); // R4

        AST_MEM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && ld_idx == 2'(i) && ld_val[7:6] != 2'b01)
                |=> (!maps[i].periph && maps[i].wen == $past(ld_val[7])
                     && maps[i].bank == ($past(ld_val[6:0]) & BANK_MASK))); // R5
    end

endmodule

// File: rtl/cbm_decode.sv
// Module: combinational address decode for one bus cycle.
// Picks the page, detects bank loads, forms the SRAM address and the
// controller selects, and gates the write strobes by the page mapping.
// Assumes strobes are already valid in the cycle they are sampled.
module cbm_decode
    import cbm_pkg::*;
#(
    parameter int BANK_W = 7,
    parameter int SA_W   = 20
) (
    input  logic                       slot_sel,
    input  logic [15:0]                cpu_addr,
    input  logic                       cpu_rd,
    input  logic                       cpu_wr,
    input  page_map_t [PAGE_COUNT-1:0] maps,
    output logic                       bank_ld,
    output logic                       in_win,
    output logic                       cur_periph,
    output logic                       periph_rd,
    output logic                       sram_we,
    output logic                       ctl_wr,
    output logic                       ctl_dsel,
    output logic [3:0]                 ctl_reg,
    output logic [SA_W-1:0]            sram_addr
);

    logic [2:0]  seg;        // 8 KB segment of the 64 KB space
    logic [1:0]  page;
    logic        bank_rng;
    page_map_t   cur;

    // Purpose: locate the page and classify the address.
    always_comb begin
        seg      = cpu_addr[15:13];
        in_win   = (seg >= 3'd2) && (seg <= 3'd5);
        page     = 2'(seg - 3'd2);
        bank_rng = (seg == 3'd3);
        cur      = maps[page];
    end

    // Purpose: form strobes and selects for this cycle.
    always_comb begin
        cur_periph = in_win && cur.periph;
        bank_ld    = slot_sel && cpu_wr && bank_rng;
        sram_we    = slot_sel && cpu_wr && in_win && !bank_rng
                     && !cur.periph && cur.wen;
        ctl_wr     = slot_sel && cpu_wr && in_win && !bank_rng && cur.periph;
        periph_rd  = slot_sel && cpu_rd && cur_periph;
        ctl_dsel   = !cpu_addr[12];
        ctl_reg    = cpu_addr[3:0];
        sram_addr  = SA_W'({cur.bank, cpu_addr[PAGE_BITS-1:0]});
    end

    if (BANK_W + PAGE_BITS != SA_W) begin : g_width_bad
        $error("sram address width does not match bank width");
    end

endmodule

// File: rtl/cbm_ctl_seq.sv
// Module: sequential strobes toward the controller.
// Makes one read pulse per read access (reads of the data register have
// side effects) and holds the controller in reset until the first edge
// after the mapper leaves reset.
module cbm_ctl_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic periph_rd,
    output logic ctl_rd,
    output logic ctl_rst
);

    logic rd_q;

    // Purpose: remember whether the previous cycle was already a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= periph_rd;
    end

    // Purpose: drive the controller reset from the mapper reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_rst <= 1'b1;
        else        ctl_rst <= 1'b0;
    end

    // Purpose: pass only the first cycle of a read access.
    always_comb ctl_rd = periph_rd && !rd_q;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && periph_rd) |=> !ctl_rd); // R8

endmodule

// File: rtl/cbm_rdata_mux.sv
// Module: read data steering to the CPU.
// Returns 0xFF when the slot is not selected or the address is outside the
// mapped window; otherwise the controller or SRAM data of the current page.
module cbm_rdata_mux (
    input  logic       slot_sel,
    input  logic       in_win,
    input  logic       cur_periph,
    input  logic [7:0] sram_rdata,
    input  logic [7:0] ctl_rdata,
    output logic [7:0] cpu_rdata
);

    // Purpose: select the read source.
    always_comb begin
        if (!slot_sel || !in_win) cpu_rdata = 8'hFF;
        else if (cur_periph)      cpu_rdata = ctl_rdata;
        else                      cpu_rdata = sram_rdata;
    end

endmodule

// File: rtl/cart_bank_mapper.sv
// Module: banked SRAM cartridge mapper with a peripheral register window.
// Four 8 KB pages over 0x4000-0xBFFF, each bank-switched by a write into
// 0x6000-0x7FFF. Assumes a synchronous one-cycle bus, an SRAM with
// combinational read and clocked write, and a controller with the same.
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int SRAM_KB = 1024,
    localparam int BANK_W = $clog2(SRAM_KB / 8),
    localparam int SA_W   = $clog2(SRAM_KB) + 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_sel,
    input  logic [15:0]     cpu_addr,
    input  logic [7:0]      cpu_wdata,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    output logic [7:0]      cpu_rdata,
    output logic [SA_W-1:0] sram_addr,
    output logic [7:0]      sram_wdata,
    output logic            sram_we,
    input  logic [7:0]      sram_rdata,
    output logic [3:0]      ctl_reg,
    output logic            ctl_dsel,
    output logic            ctl_rd,
    output logic            ctl_wr,
    output logic [7:0]      ctl_wdata,
    input  logic [7:0]      ctl_rdata,
    output logic            ctl_rst
);

    if (SRAM_KB != 128 && SRAM_KB != 256 && SRAM_KB != 512 && SRAM_KB != 1024)
    begin : g_size_bad
        $error("SRAM_KB must be 128, 256, 512 or 1024");
    end

    page_map_t [PAGE_COUNT-1:0] maps;
    logic bank_ld, in_win, cur_periph, periph_rd;

    cbm_page_regs #(.SRAM_KB(SRAM_KB)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (bank_ld),
        .ld_idx (cpu_addr[12:11]),
        .ld_val (cpu_wdata),
        .maps   (maps)
    );

    cbm_decode #(.BANK_W(BANK_W), .SA_W(SA_W)) u_dec (
        .slot_sel   (slot_sel),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .maps       (maps),
        .bank_ld    (bank_ld),
        .in_win     (in_win),
        .cur_periph (cur_periph),
        .periph_rd  (periph_rd),
        .sram_we    (sram_we),
        .ctl_wr     (ctl_wr),
        .ctl_dsel   (ctl_dsel),
        .ctl_reg    (ctl_reg),
        .sram_addr  (sram_addr)
    );

    cbm_ctl_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_rd (periph_rd),
        .ctl_rd    (ctl_rd),
        .ctl_rst   (ctl_rst)
    );

    cbm_rdata_mux u_mux (
        .slot_sel   (slot_sel),
        .in_win     (in_win),
        .cur_periph (cur_periph),
        .sram_rdata (sram_rdata),
        .ctl_rdata  (ctl_rdata),
        .cpu_rdata  (cpu_rdata)
    );

    // Purpose: write data goes to both targets; strobes pick the receiver.
    always_comb begin
        sram_wdata = cpu_wdata;
        ctl_wdata  = cpu_wdata;
    end

    AST_BANK_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_sel && cpu_wr && cpu_addr[15:13] == 3'd3) |-> (!sram_we && !ctl_wr)); // R2

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_we && ctl_wr)); // R4

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_sel |-> (!sram_we && !ctl_wr && !ctl_rd && cpu_rdata == 8'hFF)); // R6

endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

    localparam int KB   = 128;
    localparam int SA_W = 17;

    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    logic            rst_n = 1'b0, slot_sel = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [15:0]     cpu_addr = '0;
    logic [7:0]      cpu_wdata = '0, cpu_rdata, sram_wdata, sram_rdata, ctl_wdata, ctl_rdata;
    logic [SA_W-1:0] sram_addr;
    logic            sram_we, ctl_dsel, ctl_rd, ctl_wr, ctl_rst;
    logic [3:0]      ctl_reg;

    cart_bank_mapper #(.SRAM_KB(KB)) dut (
        .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_we(sram_we), .sram_rdata(sram_rdata), .ctl_reg(ctl_reg),
        .ctl_dsel(ctl_dsel), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_rst(ctl_rst)
    );

    // Sparse SRAM model with a computed background pattern.
    function automatic logic [7:0] dflt(input logic [SA_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
    endfunction
    logic [7:0] mem [int];
    int mem_ver = 0;
    always @(posedge clk) if (sram_we) begin
        mem[int'(sram_addr)] = sram_wdata;
        mem_ver = mem_ver + 1;
    end
    always @(sram_addr or mem_ver)
        sram_rdata = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : dflt(sram_addr);

    // Controller model: 16 registers plus a data register that advances on read.
    logic [7:0] cregs [16];
    logic [7:0] dreg;
    int rd_pulses = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) cregs[i] <= 8'h00;
            dreg <= 8'hC0;
        end else begin
            if (ctl_rd && ctl_dsel) dreg <= dreg + 8'd1;
            if (ctl_wr) begin
                if (ctl_dsel) dreg <= ctl_wdata;
                else          cregs[ctl_reg] <= ctl_wdata;
            end
        end
        if (rst_n && ctl_rd) rd_pulses <= rd_pulses + 1;
    end
    always_comb ctl_rdata = ctl_dsel ? dreg : cregs[ctl_reg];

    int n_chk = 0, n_bad = 0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [7:0] r_data;
    logic       r_we, r_cwr, r_crd;

    // One bus cycle: drive at negedge, sample before the next posedge.
    task automatic access(input logic is_wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = is_wr; cpu_rd = !is_wr;
        #1;
        r_data = cpu_rdata; r_we = sram_we; r_cwr = ctl_wr; r_crd = ctl_rd;
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h6000, 8'h83, 8'h00, 4'd2},  // R2 page0 -> bank3, writable
        '{1'b1, 16'h4010, 8'h5A, 8'h00, 4'd1},
        '{1'b0, 16'h4010, 8'h00, 8'h5A, 4'd1},  // R1
        '{1'b1, 16'h7000, 8'h02, 8'h00, 4'd2},  // page2 -> bank2 read-only
        '{1'b1, 16'h8020, 8'h11, 8'h00, 4'd3},
        '{1'b0, 16'h8020, 8'h00, 8'h60, 4'd3},  // R3 write ignored
        '{1'b1, 16'h7800, 8'h93, 8'h00, 4'd5},  // R5 0x93 folds to bank3
        '{1'b0, 16'hA010, 8'h00, 8'h5A, 4'd5},
        '{1'b1, 16'h7800, 8'hBE, 8'h00, 4'd5},  // bank 0x3E -> 0xE
        '{1'b1, 16'hA123, 8'h77, 8'h00, 4'd5},
        '{1'b0, 16'hA123, 8'h00, 8'h77, 4'd5},
        '{1'b1, 16'h6000, 8'h8E, 8'h00, 4'd2},
        '{1'b0, 16'h4123, 8'h00, 8'h77, 4'd1},  // R1 same block via page0
        '{1'b1, 16'h7000, 8'h7F, 8'h00, 4'd4},  // R4 page2 -> controller
        '{1'b1, 16'h9005, 8'h33, 8'h00, 4'd4},
        '{1'b0, 16'h9F15, 8'h00, 8'h33, 4'd4},  // register 5 via mirror
        '{1'b1, 16'h6800, 8'h40, 8'h00, 4'd9},  // page1 -> controller
        '{1'b0, 16'h6005, 8'h00, 8'hC0, 4'd9},  // R9 data register read
        '{1'b0, 16'h8FFF, 8'h00, 8'hC1, 4'd4},
        '{1'b1, 16'h8ABC, 8'h99, 8'h00, 4'd4},
        '{1'b0, 16'h8000, 8'h00, 8'h99, 4'd4},
        '{1'b1, 16'h6800, 8'hC5, 8'h00, 4'd4},  // 11xxxxxx stays memory
        '{1'b0, 16'h7000, 8'h00, 8'hB0, 4'd9},  // R9 page1 bank5
        '{1'b0, 16'h0000, 8'h00, 8'hFF, 4'd6},  // R6
        '{1'b0, 16'hC000, 8'h00, 8'hFF, 4'd6}
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R7 ctl_rst in reset", {7'b0, ctl_rst}, 8'h01);
        @(negedge clk); rst_n = 1'b1; slot_sel = 1'b1;
        @(posedge clk); #1;
        check("R7 ctl_rst released", {7'b0, ctl_rst}, 8'h00);

        // Reset state: page0 bank0 read-only.
        access(1'b0, 16'h4000, 8'h00);
        check("R7 reset bank0 read", r_data, dflt('0));
        access(1'b1, 16'h4000, 8'hAA);
        check("R7 reset read-only we", {7'b0, r_we}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].a, VEC[i].d);
            if (!VEC[i].wr) begin
                n_chk++;
                if (r_data !== VEC[i].e) begin
                    n_bad++;
                    $display("FAIL vector %0d (R%0d): actual %h expected %h",
                             i, VEC[i].req, r_data, VEC[i].e);
                end
            end
        end

        // R2: bank load reaches neither target.
        access(1'b1, 16'h6000, 8'h8E);
        check("R2 bank load sram_we", {7'b0, r_we}, 8'h00);
        check("R2 bank load ctl_wr", {7'b0, r_cwr}, 8'h00);

        // R8: held read gives one pulse and one data-register advance.
        rd_pulses = 0;
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_rd = 1'b1;
        repeat (3) @(negedge clk);
        cpu_rd = 1'b0;
        @(posedge clk); #1;
        check("R8 pulses", 8'(rd_pulses), 8'd1);
        access(1'b0, 16'h8000, 8'h00);
        check("R8 data after held read", r_data, 8'h9B);

        // R6: deselected accesses.
        slot_sel = 1'b0;
        access(1'b1, 16'h4123, 8'h00);
        check("R6 unselected we", {7'b0, r_we}, 8'h00);
        access(1'b0, 16'h4123, 8'h00);
        check("R6 unselected read", r_data, 8'hFF);
        slot_sel = 1'b1;
        access(1'b0, 16'h4123, 8'h00);
        check("R6 data kept", r_data, 8'h77);

        // R7: reset mid-run clears all mappings.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 ctl_rst again", {7'b0, ctl_rst}, 8'h01);
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 16'h8000, 8'h00);
        check("R7 page2 back to memory", r_data, dflt('0));
        check("R7 no ctl_rd", {7'b0, r_crd}, 8'h00);
        access(1'b1, 16'hA000, 8'h55);
        check("R7 page3 read-only", {7'b0, r_we}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule